// File: doc/BRIEF.md
# RV32I Instruction Control Decoder

This block turns one 32-bit RV32I instruction word into the full set of datapath control signals for that instruction in a single combinational pass. Bits [6:2] of the instruction form an opcode group that is decoded one-hot. A set of gate networks over the decoded groups then produces the immediate format, the ALU operand sources, a 5-bit ALU operation code, a 5-bit branch/jump selector, memory strobes with a byte-lane code, the register write enable and the writeback source. It also produces the ecall and ebreak trap flags and the register index fields.

Two detectors limit side effects. A no-op detector fires when the rs1, rs2, rd and funct7 fields are all zero. It is combined with the system-opcode group into one suppression term, which forces every write-type output low. Source register indices are driven as zero for instructions that read no source register, so the downstream hazard logic sees no false dependency. The block contains no state. It sits between the instruction register and the pipeline register of the decode stage.

Top module: `rv_ctl_decoder`

## Requirements
- R1: Only opcode groups 0 (load), 4 (register-immediate), 5 (add upper immediate to PC), 8 (store), 12 (register-register), 13 (load upper immediate), 24 (branch), 25 (jump register), 27 (jump) and 28 (system) have defined controls. Every other group, including 3 and 14, gives imm_fmt=000, opa_pc=0, opb_imm=0, br_ctl[4:3]=00, rf_we=0, mem_rd=0, mem_wr=0, wb_src=00 and no trap flag. Bits [1:0] of the word are not decoded.
- R2: imm_fmt[0] is set for store, load-upper and add-upper-to-PC. imm_fmt[1] is set for branch, load-upper and add-upper-to-PC. imm_fmt[2] is set for jump. All other groups give 000.
- R3: opa_pc is 1 for add-upper-to-PC, branch and jump. opb_imm is 1 for register-immediate, load, store, add-upper-to-PC, jump and jump-register.
- R4: alu_op[2:0] equals funct3 (bits [14:12]). alu_op[3] equals bit 30 and alu_op[4] equals bit 25, each only when the group is register-register or a register-immediate right shift (funct3=101); otherwise both are 0.
- R5: br_ctl[3] flags branch and br_ctl[4] flags jump or jump-register. br_ctl[2:0] carries funct3 when one of those flags is set and is 000 otherwise. A branch-if-equal gives 01000.
- R6: Suppression is active when bits [31:15] and [11:7] are all zero, or when the group is system. Under suppression, rf_we, mem_rd, mem_wr and mem_lanes are all 0.
- R7: rf_we is 1 only for unsuppressed load, register-immediate, add-upper-to-PC, register-register, load-upper, jump-register and jump. It is never 1 for store or branch.
- R8: mem_rd is 1 only for an unsuppressed load. mem_wr is 1 only for an unsuppressed store.
- R9: When not suppressed, mem_lanes = {funct3[1], funct3[0], funct3[2]}, that is bit0=funct3[2], bit1=funct3[0] and bit2=funct3[1]. A word access (funct3=010) gives 100.
- R10: wb_src is 10 (PC+4) for jump and jump-register, 01 (memory data) for load and 00 (ALU result) otherwise. It is 00 whenever rf_we is 0.
- R11: rs1_idx and rs2_idx are 0 for load-upper, add-upper-to-PC and jump, and equal bits [19:15] and [24:20] otherwise. rd_idx always equals bits [11:7] and opcode_raw always equals bits [6:0].
- R12: For the system group, bit 20 = 0 raises trap_ecall and bit 20 = 1 raises trap_ebreak. Neither flag is raised for any other group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inst_word | input | 32 | Instruction word being decoded |
| imm_fmt | output | 3 | Immediate format code for the immediate generator |
| opa_pc | output | 1 | ALU operand A takes the PC |
| opb_imm | output | 1 | ALU operand B takes the immediate |
| alu_op | output | 5 | ALU operation code |
| br_ctl | output | 5 | {jump, branch, funct3} selector for branch evaluation |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| mem_lanes | output | 3 | Permuted access-size code for the data memory |
| rf_we | output | 1 | Register file write enable |
| wb_src | output | 2 | Writeback source select |
| trap_ecall | output | 1 | Environment call flag |
| trap_ebreak | output | 1 | Breakpoint flag |
| opcode_raw | output | 7 | Bits [6:0] passed through |
| rd_idx | output | 5 | Destination register index |
| rs1_idx | output | 5 | First source index, zeroed when unused |
| rs2_idx | output | 5 | Second source index, zeroed when unused |

## Verification
The assertions assume that the instruction word settles to a defined value before the outputs are examined, and they draw no conclusion from bits [1:0]. Both the directed vectors and the pseudo-random vectors change the word only just after a bench clock edge, and results are read half a period later. The random vectors cover all 32 opcode groups and arbitrary field contents, including the undefined groups. The directed set covers the all-zero-field no-op, suppressed loads and stores, both right-shift forms and both trap encodings.

// File: rtl/rv_ctl_pkg.sv
// Package: shared field geometry and opcode-group codes for the control decoder.
// Assumes a 32-bit RV32I instruction word with the standard field layout.
package rv_ctl_pkg;
    localparam int INST_W   = 32;
    localparam int OPC_W    = 7;
    localparam int GRP_LSB  = 2;
    localparam int GRP_W    = OPC_W - GRP_LSB;
    localparam int REG_W    = 5;
    localparam int F3_W     = 3;
    localparam int F7_W     = 7;
    localparam int RD_LSB   = OPC_W;
    localparam int F3_LSB   = RD_LSB + REG_W;
    localparam int RS1_LSB  = F3_LSB + F3_W;
    localparam int RS2_LSB  = RS1_LSB + REG_W;
    localparam int F7_LSB   = RS2_LSB + REG_W;
    localparam int TRAP_BIT = RS2_LSB;

    // Opcode group codes (bits [6:2]); these values are behaviour.
    localparam int GRP_LOAD   = 0;
    localparam int GRP_OPIMM  = 4;
    localparam int GRP_AUIPC  = 5;
    localparam int GRP_STORE  = 8;
    localparam int GRP_OP     = 12;
    localparam int GRP_LUI    = 13;
    localparam int GRP_BRANCH = 24;
    localparam int GRP_JALR   = 25;
    localparam int GRP_JAL    = 27;
    localparam int GRP_SYSTEM = 28;

    localparam logic [F3_W-1:0] F3_SHR = 3'b101;

    typedef enum logic [1:0] {
        WB_ALU  = 2'b00,
        WB_MEM  = 2'b01,
        WB_LINK = 2'b10
    } wb_src_e;

    typedef struct packed {
        logic load;
        logic opimm;
        logic auipc;
        logic store;
        logic op;
        logic lui;
        logic branch;
        logic jalr;
        logic jal;
        logic system;
    } grp_cls_t;
endpackage

// File: rtl/rv_ctl_onehot.sv
// Module: binary-to-one-hot decoder for the opcode group.
// Assumes sel is a defined binary value; exactly one output bit is high.
module rv_ctl_onehot #(
    parameter int SEL_W = 5
) (
    input  logic [SEL_W-1:0]      sel,
    output logic [(1<<SEL_W)-1:0] hot
);
    localparam int N_OUT = 1 << SEL_W;

    // One comparator per output line.
    for (genvar g = 0; g < N_OUT; g++) begin : g_line
        assign hot[g] = (sel == SEL_W'(g));
    end
endmodule

// File: rtl/rv_ctl_suppress.sv
// Module: no-op field detector merged with the system group into a suppression term.
// Assumes the caller supplies the raw instruction fields.
module rv_ctl_suppress #(
    parameter int REG_W = 5,
    parameter int F7_W  = 7
) (
    input  logic [REG_W-1:0] rd,
    input  logic [REG_W-1:0] rs1,
    input  logic [REG_W-1:0] rs2,
    input  logic [F7_W-1:0]  f7,
    input  logic             is_system,
    output logic             suppress
);
    logic nop_hit;

    // All register fields and funct7 zero marks a no-op.
    always_comb nop_hit = (rd == '0) && (rs1 == '0) && (rs2 == '0) && (f7 == '0);

    // Either source blocks all write-type outputs.
    always_comb suppress = nop_hit | is_system;
endmodule

// File: rtl/rv_ctl_fields.sv
// Module: field-derived outputs (ALU code, memory lanes, source index masking).
// Assumes alu_qual is already restricted to register-register or immediate right shift.
module rv_ctl_fields #(
    parameter int REG_W = 5,
    parameter int F3_W  = 3,
    parameter int F7_W  = 7
) (
    input  logic [F3_W-1:0]  f3,
    input  logic [F7_W-1:0]  f7,
    input  logic             alu_qual,
    input  logic             suppress,
    input  logic             zero_src,
    input  logic [REG_W-1:0] rs1,
    input  logic [REG_W-1:0] rs2,
    output logic [4:0]       alu_op,
    output logic [2:0]       mem_lanes,
    output logic [REG_W-1:0] rs1_idx,
    output logic [REG_W-1:0] rs2_idx
);
    localparam int F7_ALT = 5;

    // ALU code: funct3 plus qualified funct7 modifier bits.
    always_comb alu_op = {f7[0] & alu_qual, f7[F7_ALT] & alu_qual, f3};

    // Lane code is a fixed permutation of funct3, blanked under suppression.
    always_comb mem_lanes = suppress ? 3'b000 : {f3[1], f3[0], f3[2]};

    // Source indices masked when the instruction reads no register.
    always_comb begin
        rs1_idx = zero_src ? '0 : rs1;
        rs2_idx = zero_src ? '0 : rs2;
    end
endmodule

// File: rtl/rv_ctl_decoder.sv
// Module: top of the RV32I control decoder; purely combinational.
// Assumes inst_word holds the instruction of the current decode slot.
module rv_ctl_decoder
    import rv_ctl_pkg::*;
(
    input  logic [INST_W-1:0] inst_word,
    output logic [2:0]        imm_fmt,
    output logic              opa_pc,
    output logic              opb_imm,
    output logic [4:0]        alu_op,
    output logic [4:0]        br_ctl,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [2:0]        mem_lanes,
    output logic              rf_we,
    output logic [1:0]        wb_src,
    output logic              trap_ecall,
    output logic              trap_ebreak,
    output logic [OPC_W-1:0]  opcode_raw,
    output logic [REG_W-1:0]  rd_idx,
    output logic [REG_W-1:0]  rs1_idx,
    output logic [REG_W-1:0]  rs2_idx
);
    localparam int N_GRP = 1 << GRP_W;

    logic [N_GRP-1:0] hot;
    grp_cls_t         cls;
    logic [F3_W-1:0]  f3;
    logic [F7_W-1:0]  f7;
    logic [REG_W-1:0] rd_f, rs1_f, rs2_f;
    logic             suppress, alu_qual, zero_src, writer;
    logic             unused_hot;

    // Field extraction from the instruction word.
    always_comb begin
        f3    = inst_word[F3_LSB +: F3_W];
        f7    = inst_word[F7_LSB +: F7_W];
        rd_f  = inst_word[RD_LSB +: REG_W];
        rs1_f = inst_word[RS1_LSB +: REG_W];
        rs2_f = inst_word[RS2_LSB +: REG_W];
    end

    rv_ctl_onehot #(.SEL_W(GRP_W)) u_hot (
        .sel (inst_word[OPC_W-1:GRP_LSB]),
        .hot (hot)
    );

    // Pick the defined groups out of the one-hot vector.
    always_comb begin
        cls.load   = hot[GRP_LOAD];
        cls.opimm  = hot[GRP_OPIMM];
        cls.auipc  = hot[GRP_AUIPC];
        cls.store  = hot[GRP_STORE];
        cls.op     = hot[GRP_OP];
        cls.lui    = hot[GRP_LUI];
        cls.branch = hot[GRP_BRANCH];
        cls.jalr   = hot[GRP_JALR];
        cls.jal    = hot[GRP_JAL];
        cls.system = hot[GRP_SYSTEM];
    end

    // Remaining group lines carry no controls.
    assign unused_hot = ^hot;

    rv_ctl_suppress #(.REG_W(REG_W), .F7_W(F7_W)) u_sup (
        .rd        (rd_f),
        .rs1       (rs1_f),
        .rs2       (rs2_f),
        .f7        (f7),
        .is_system (cls.system),
        .suppress  (suppress)
    );

    // Qualifiers for the ALU modifier bits and the source masking.
    always_comb begin
        alu_qual = cls.op | (cls.opimm & (f3 == F3_SHR));
        zero_src = cls.lui | cls.auipc | cls.jal;
    end

    rv_ctl_fields #(.REG_W(REG_W), .F3_W(F3_W), .F7_W(F7_W)) u_fld (
        .f3        (f3),
        .f7        (f7),
        .alu_qual  (alu_qual),
        .suppress  (suppress),
        .zero_src  (zero_src),
        .rs1       (rs1_f),
        .rs2       (rs2_f),
        .alu_op    (alu_op),
        .mem_lanes (mem_lanes),
        .rs1_idx   (rs1_idx),
        .rs2_idx   (rs2_idx)
    );

    // Group-driven operand, immediate and branch controls.
    always_comb begin
        imm_fmt = {cls.jal,
                   cls.branch | cls.lui | cls.auipc,
                   cls.store  | cls.lui | cls.auipc};
        opa_pc  = cls.auipc | cls.branch | cls.jal;
        opb_imm = cls.opimm | cls.load | cls.store | cls.auipc | cls.jal | cls.jalr;
        br_ctl[4]   = cls.jal | cls.jalr;
        br_ctl[3]   = cls.branch;
        br_ctl[2:0] = (br_ctl[4] | br_ctl[3]) ? f3 : 3'b000;
    end

    // Write-type enables gated by suppression, and writeback source.
    always_comb begin
        writer = cls.load | cls.opimm | cls.auipc | cls.op | cls.lui | cls.jalr | cls.jal;
        rf_we  = writer & ~suppress;
        mem_rd = cls.load  & ~suppress;
        mem_wr = cls.store & ~suppress;
        if (!rf_we)
            wb_src = WB_ALU;
        else if (cls.jal | cls.jalr)
            wb_src = WB_LINK;
        else if (cls.load)
            wb_src = WB_MEM;
        else
            wb_src = WB_ALU;
    end

    // Trap flags and raw passthroughs.
    always_comb begin
        trap_ecall  = cls.system & ~inst_word[TRAP_BIT];
        trap_ebreak = cls.system &  inst_word[TRAP_BIT];
        opcode_raw  = inst_word[OPC_W-1:0];
        rd_idx      = rd_f;
    end
endmodule

// File: rtl/rv_ctl_decoder_chk.sv
// Module: checker of output relations for the control decoder, bound to the top.
// Assumes outputs are settled whenever the combinational block re-evaluates.
module rv_ctl_decoder_chk
    import rv_ctl_pkg::*;
(
    input logic [INST_W-1:0] inst_word,
    input logic [2:0]        imm_fmt,
    input logic              opa_pc,
    input logic              opb_imm,
    input logic [4:0]        alu_op,
    input logic [4:0]        br_ctl,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [2:0]        mem_lanes,
    input logic              rf_we,
    input logic [1:0]        wb_src,
    input logic              trap_ecall,
    input logic              trap_ebreak,
    input logic [OPC_W-1:0]  opcode_raw,
    input logic [REG_W-1:0]  rd_idx,
    input logic [REG_W-1:0]  rs1_idx,
    input logic [REG_W-1:0]  rs2_idx
);
    logic fields_zero;
    logic unused_chk;

    assign unused_chk  = ^{opa_pc, opb_imm, alu_op, opcode_raw, rd_idx, imm_fmt[2]};
    assign fields_zero = (inst_word[INST_W-1:RS1_LSB] == '0) && (inst_word[RD_LSB +: REG_W] == '0);

    // Output relations checked on every change.
    always_comb begin
        p_mem_excl_r8: assert (!(mem_rd && mem_wr))
            else $error("read and write strobes together");
        p_suppress_r6: assert (!fields_zero || (!rf_we && !mem_rd && !mem_wr && mem_lanes == 3'b000))
            else $error("write outputs active on a no-op word");
        p_trap_excl_r12: assert (!(trap_ecall && trap_ebreak))
            else $error("both trap flags raised");
        p_trap_quiet_r6: assert (!(trap_ecall || trap_ebreak) || (!rf_we && !mem_rd && !mem_wr))
            else $error("trap word enables a write");
        p_wb_idle_r10: assert (rf_we || wb_src == 2'b00)
            else $error("writeback source set without write");
        p_load_wb_r10: assert (!mem_rd || (rf_we && wb_src == 2'b01))
            else $error("load without memory writeback");
        p_branch_nowr_r7: assert (!br_ctl[3] || (!rf_we && !mem_wr))
            else $error("branch writes state");
        p_upper_src_r11: assert (!(imm_fmt[1] && imm_fmt[0]) || (rs1_idx == '0 && rs2_idx == '0))
            else $error("upper-immediate group exposes source index");
    end
endmodule

bind rv_ctl_decoder rv_ctl_decoder_chk u_chk (.*);

// File: tb/rv_ctl_decoder_test.sv
// Bench: scoreboard for the control decoder; driver queues expected bundles, monitor compares.
module rv_ctl_decoder_test;
    localparam int MAX_CYC = 20000;
    localparam int N_RAND  = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] inst_word = 32'h0;
    logic [2:0]  imm_fmt;
    logic        opa_pc, opb_imm, mem_rd, mem_wr, rf_we, trap_ecall, trap_ebreak;
    logic [4:0]  alu_op, br_ctl, rd_idx, rs1_idx, rs2_idx;
    logic [2:0]  mem_lanes;
    logic [1:0]  wb_src;
    logic [6:0]  opcode_raw;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [46:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    rv_ctl_decoder uut (
        .inst_word(inst_word), .imm_fmt(imm_fmt), .opa_pc(opa_pc), .opb_imm(opb_imm),
        .alu_op(alu_op), .br_ctl(br_ctl), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_lanes(mem_lanes), .rf_we(rf_we), .wb_src(wb_src), .trap_ecall(trap_ecall),
        .trap_ebreak(trap_ebreak), .opcode_raw(opcode_raw), .rd_idx(rd_idx),
        .rs1_idx(rs1_idx), .rs2_idx(rs2_idx)
    );

    // Expected bundle built from the requirement text.
    function automatic logic [46:0] model(input logic [31:0] w);
        logic [4:0] grp = w[6:2];
        logic [2:0] f3 = w[14:12];
        logic [6:0] f7 = w[31:25];
        logic [2:0] imm = 3'b000;
        logic a = 0, b = 0, br = 0, jp = 0, rd = 0, wr = 0, we = 0, ec = 0, eb = 0;
        logic q = 0, zs = 0, sup;
        logic [1:0] wb = 2'b00;
        logic [2:0] lanes, brl;
        logic [4:0] alu;
        sup = (grp == 5'd28) || (w[31:15] == 17'h0 && w[11:7] == 5'h0);
        case (grp)
            5'd0:  begin b = 1; we = 1; rd = 1; wb = 2'b01; end
            5'd4:  begin b = 1; we = 1; q = (f3 == 3'b101); end
            5'd5:  begin imm = 3'b011; a = 1; b = 1; we = 1; zs = 1; end
            5'd8:  begin imm = 3'b001; b = 1; wr = 1; end
            5'd12: begin we = 1; q = 1; end
            5'd13: begin imm = 3'b011; we = 1; zs = 1; end
            5'd24: begin imm = 3'b010; a = 1; br = 1; end
            5'd25: begin b = 1; we = 1; jp = 1; wb = 2'b10; end
            5'd27: begin imm = 3'b100; a = 1; b = 1; we = 1; jp = 1; wb = 2'b10; zs = 1; end
            5'd28: begin ec = ~w[20]; eb = w[20]; end
            default: ;
        endcase
        if (sup) begin we = 0; rd = 0; wr = 0; end
        lanes = sup ? 3'b000 : {f3[1], f3[0], f3[2]};
        if (!we) wb = 2'b00;
        alu = {f7[0] & q, f7[5] & q, f3};
        brl = (br | jp) ? f3 : 3'b000;
        return {imm, a, b, alu, jp, br, brl, rd, wr, lanes, we, wb, ec, eb,
                w[6:0], w[11:7], zs ? 5'd0 : w[19:15], zs ? 5'd0 : w[24:20]};
    endfunction

    // Driver: apply a word after a clock edge and queue its expected bundle.
    task automatic drive(input logic [31:0] w, input string tag);
        @(posedge clk);
        #1;
        inst_word = w;
        sb_q.push_back('{model(w), tag});
    endtask

    // Driver variant with a literal expected value for selected reference vectors.
    task automatic drive_lit(input logic [31:0] w, input logic [46:0] e, input string tag);
        @(posedge clk);
        #1;
        inst_word = w;
        sb_q.push_back('{e, tag});
    endtask

    // Monitor: pop and compare half a period after each drive.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            logic [46:0] act;
            it = sb_q.pop_front();
            act = {imm_fmt, opa_pc, opb_imm, alu_op, br_ctl, mem_rd, mem_wr, mem_lanes,
                   rf_we, wb_src, trap_ecall, trap_ebreak, opcode_raw, rd_idx, rs1_idx, rs2_idx};
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s inst=%08h actual=%012h expected=%012h", it.tag, inst_word, act, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_1234;
        // Reset state: all-zero word during reset, must decode as a suppressed load (R6).
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (rf_we !== 1'b0 || mem_rd !== 1'b0 || mem_lanes !== 3'b000) begin
            failures++;
            $display("FAIL R6 reset word actual=%b%b%03b expected=00000", rf_we, mem_rd, mem_lanes);
        end
        rst_n = 1'b1;

        // Literal references: add has all outputs quiet except rf_we and fields (R7).
        drive_lit(32'h00208033, {3'b000, 1'b0, 1'b0, 5'b00000, 5'b00000, 1'b0, 1'b0, 3'b000,
                                 1'b1, 2'b00, 1'b0, 1'b0, 7'h33, 5'd0, 5'd1, 5'd2}, "R7 add");
        // Branch-if-equal gives br_ctl 01000 (R5).
        drive_lit(32'h00208463, {3'b010, 1'b1, 1'b0, 5'b00000, 5'b01000, 1'b0, 1'b0, 3'b000,
                                 1'b0, 2'b00, 1'b0, 1'b0, 7'h63, 5'd8, 5'd1, 5'd2}, "R5 beq");
        // Word load lanes 100 (R9, R8).
        drive_lit(32'h0040a103, {3'b000, 1'b0, 1'b1, 5'b00010, 5'b00000, 1'b1, 1'b0, 3'b100,
                                 1'b1, 2'b01, 1'b0, 1'b0, 7'h03, 5'd2, 5'd1, 5'd4}, "R9 lw");

        drive(32'h0020a223, "R8 sw");
        drive(32'h008000ef, "R2 jal");
        drive(32'h123450b7, "R11 lui");
        drive(32'h00001097, "R11 auipc");
        drive(32'h000080e7, "R10 jalr");
        drive(32'h00000013, "R6 canonical nop");
        drive(32'h00002023, "R6 suppressed store");
        drive(32'h00002003, "R6 suppressed load");
        drive(32'h0020803b, "R1 group 14");
        drive(32'h0ff0000f, "R1 group 3");
        drive(32'h0020807f, "R1 group 31");
        drive(32'h4020d093, "R4 shift right arith imm");
        drive(32'h4020c093, "R4 xor imm no modifier");
        drive(32'h402080b3, "R4 sub");
        drive(32'h022080b3, "R4 funct7 bit0");
        drive(32'hfff08093, "R3 addi negative");
        drive(32'h00000073, "R12 ecall");
        drive(32'h00100073, "R12 ebreak");
        drive(32'h0040c103, "R9 lbu");
        drive(32'h00409103, "R9 lh");
        drive(32'h0020f863, "R5 bgeu");

        // Pseudo-random sweep over all groups and field contents.
        for (int i = 0; i < N_RAND; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = lfsr * 32'd1103515245 + 32'd12345;
            drive(lfsr, "R1 random");
        end

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule